// File: doc/BRIEF.md
# Fractional Oscillator Code Dither Modulator

This block lets a digitally controlled oscillator behave as if its tuning step were finer than it really is. A loop controller in a slow clock domain, running at the line-sync rate, supplies an integer tuning code and a fractional code. The modulator runs on the fast pixel clock that the oscillator produces. Every fast cycle it emits either the integer code or the integer code plus one. The long-run mean of its output equals integer plus fraction.

The modulator is a first-order error-feedback loop. An accumulator as wide as the fraction adds the fraction to a stored residue each cycle. The carry out of that addition is the quantizer decision. Because the carries are spread as evenly as the arithmetic allows, the phase error accumulated over a line stays below one oscillator step.

The two codes cross from the slow domain under a toggle flag that passes through a two-flop synchronizer. Both codes are then captured together, so no torn value is used. The fraction width is a parameter. With a width of zero, the block passes the integer code straight through.

Top module: `dco_dither_mod`

## Requirements
- R1: A synchronous active-high reset in each domain clears that domain's state: the held codes and the toggle flag on the slow side; the captured codes, the residue and the output code on the fast side. The output code reads 0 after reset.
- R2: Every fast cycle the output code equals the captured integer code or the captured integer code plus one.
- R3: With FRAC_W = 6 and a constant fraction f (0 to 63), any 64 consecutive fast cycles contain exactly f outputs equal to integer plus one.
- R4: The running sum of (output − integer − f/2^FRAC_W), taken in fast cycles from any point, stays strictly below one oscillator step in magnitude.
- R5: A load strobe in the slow domain toggles an update flag. The fast domain passes that flag through two flops and captures the integer and fractional codes together in the same cycle, only when it sees a toggle. The new integer code reaches the output within 10 fast cycles of the slow load edge.
- R6: When a new fraction is captured, the residue is not cleared. The next residue is the old residue plus the new fraction, modulo 2^FRAC_W.
- R7: When the captured integer code is all ones, the output code equals that maximum for every fraction and never wraps.
- R8: With FRAC_W = 0, the output code equals the captured integer code every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Line-rate controller clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| load_i | input | 1 | Strobe: take int_code_i and frac_code_i |
| int_code_i | input | INT_W | Integer oscillator code from the controller |
| frac_code_i | input | max(FRAC_W,1) | Fractional code from the controller (ignored when FRAC_W = 0) |
| fast_clk | input | 1 | Pixel clock from the oscillator |
| fast_rst | input | 1 | Synchronous active-high reset, fast domain |
| dco_code_o | output | INT_W | Registered dithered oscillator code |

## Verification
Two events can fall into the same fast cycle: a code capture triggered by the synchronized toggle, and an accumulator carry. At that edge the residue must continue from its old value while it adds the new fraction. The bench provokes this by changing the fraction while a residue left by the previous fraction is still stored. The checker's continuity property judges the residue at that edge. The bench's sliding-window count and its bound on the running phase error then judge the output after the change.

A second coincidence is saturation with a carry pending. The bench loads the maximum integer with a nonzero fraction, and every sample must read the maximum.

// File: rtl/dither_pkg.sv
package dither_pkg;
  // Residue width: at least one bit so the zero-fraction variant still elaborates.
  function automatic int res_width(input int frac_w);
    return (frac_w > 0) ? frac_w : 1;
  endfunction
endpackage

// File: rtl/dither_slow_port.sv
module dither_slow_port
  import dither_pkg::*;
#(
  parameter int INT_W = 10,
  parameter int RES_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] int_in,
  input  logic [RES_W-1:0] frac_in,
  output logic [INT_W-1:0] int_hold,
  output logic [RES_W-1:0] frac_hold,
  output logic             upd_tgl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_hold  <= '0;
      frac_hold <= '0;
      upd_tgl   <= 1'b0;
    end else if (load) begin
      int_hold  <= int_in;
      frac_hold <= frac_in;
      upd_tgl   <= ~upd_tgl;
    end
  end
endmodule

// File: rtl/dither_cdc_capture.sv
module dither_cdc_capture
  import dither_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int RES_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_tgl,
  input  logic [INT_W-1:0] int_hold,
  input  logic [RES_W-1:0] frac_hold,
  output logic [INT_W-1:0] cap_int,
  output logic [RES_W-1:0] cap_frac,
  output logic             fire
);
  logic [SYNC_N-1:0] sync_q;
  logic              seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], upd_tgl};
      seen_q <= sync_q[SYNC_N-1];
    end
  end

  assign fire = sync_q[SYNC_N-1] ^ seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_int  <= '0;
      cap_frac <= '0;
    end else if (fire) begin
      cap_int  <= int_hold;
      cap_frac <= frac_hold;
    end
  end
endmodule

// File: rtl/dither_accum.sv
module dither_accum
  import dither_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 6,
  parameter int RES_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] cap_int,
  input  logic [RES_W-1:0] cap_frac,
  output logic [RES_W-1:0] residue,
  output logic [INT_W-1:0] code_out
);
  logic carry;
  logic at_max;

  assign at_max = (cap_int == {INT_W{1'b1}});

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [RES_W:0] sum;
      assign sum   = {1'b0, residue} + {1'b0, cap_frac};
      assign carry = sum[RES_W];
      always_ff @(posedge clk) begin
        if (rst) residue <= '0;
        else     residue <= sum[RES_W-1:0];
      end
    end else begin : g_int_only
      assign carry = 1'b0;
      always_ff @(posedge clk) begin
        if (rst) residue <= '0;
        else     residue <= '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         code_out <= '0;
    else if (at_max) code_out <= cap_int;
    else             code_out <= cap_int + INT_W'(carry);
  end
endmodule

// File: rtl/dco_dither_mod.sv
module dco_dither_mod
  import dither_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 6
) (
  input  logic                             slow_clk,
  input  logic                             slow_rst,
  input  logic                             load_i,
  input  logic [INT_W-1:0]                 int_code_i,
  input  logic [res_width(FRAC_W)-1:0]     frac_code_i,
  input  logic                             fast_clk,
  input  logic                             fast_rst,
  output logic [INT_W-1:0]                 dco_code_o
);
  localparam int RES_W = res_width(FRAC_W);

  logic [INT_W-1:0] int_hold;
  logic [RES_W-1:0] frac_hold;
  logic             upd_tgl;
  logic [INT_W-1:0] cap_int;
  logic [RES_W-1:0] cap_frac;
  logic             upd_fire;
  logic [RES_W-1:0] residue;

  dither_slow_port #(.INT_W(INT_W), .RES_W(RES_W)) u_slow (
    .clk(slow_clk), .rst(slow_rst), .load(load_i),
    .int_in(int_code_i), .frac_in(frac_code_i),
    .int_hold(int_hold), .frac_hold(frac_hold), .upd_tgl(upd_tgl)
  );

  dither_cdc_capture #(.INT_W(INT_W), .RES_W(RES_W), .SYNC_N(2)) u_cdc (
    .clk(fast_clk), .rst(fast_rst), .upd_tgl(upd_tgl),
    .int_hold(int_hold), .frac_hold(frac_hold),
    .cap_int(cap_int), .cap_frac(cap_frac), .fire(upd_fire)
  );

  dither_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_acc (
    .clk(fast_clk), .rst(fast_rst), .cap_int(cap_int), .cap_frac(cap_frac),
    .residue(residue), .code_out(dco_code_o)
  );
endmodule

// File: rtl/dco_dither_mod_chk.sv
module dco_dither_mod_chk #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 6,
  parameter int RES_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [INT_W-1:0] code,
  input logic [INT_W-1:0] cap_int,
  input logic [RES_W-1:0] cap_frac,
  input logic [RES_W-1:0] residue,
  input logic             fire
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (code == '0) && (residue == '0) && (cap_int == '0));

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (code == $past(cap_int)) || (code == $past(cap_int) + INT_W'(1)));

  // R5
  a_r5_capture_on_toggle: assert property (@(posedge clk) disable iff (rst)
    !$past(fire) |-> ($stable(cap_int) && $stable(cap_frac)));

  // R7
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (cap_int == {INT_W{1'b1}}) |=> (code == {INT_W{1'b1}}));

  generate
    if (FRAC_W > 0) begin : g_res
      // R6
      a_r6_residue_kept: assert property (@(posedge clk) disable iff (rst)
        residue == RES_W'($past(residue) + $past(cap_frac)));
    end else begin : g_nores
      // R8
      a_r8_passthrough: assert property (@(posedge clk) disable iff (rst)
        code == $past(cap_int));
    end
  endgenerate
endmodule

bind dco_dither_mod dco_dither_mod_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .RES_W(RES_W)
) u_chk (
  .clk(fast_clk), .rst(fast_rst), .code(dco_code_o), .cap_int(cap_int),
  .cap_frac(cap_frac), .residue(residue), .fire(upd_fire)
);

// File: tb/dco_dither_mod_bench.sv
module dco_dither_mod_bench;
  localparam int INT_W  = 10;
  localparam int FRAC_W = 6;
  localparam int PER    = 1 << FRAC_W;
  localparam int NS     = 2 * PER;

  typedef struct {
    int ival;
    int fval;
  } item_t;

  logic fast_clk = 0, slow_clk = 0;
  logic fast_rst = 1, slow_rst = 1;
  logic load = 0;
  logic [INT_W-1:0] int_code = '0;
  logic [FRAC_W-1:0] frac_code = '0;
  logic [INT_W-1:0] dco_code, dco_code_f0;

  int checks = 0, fails = 0;
  item_t sb_q[$];
  bit mon_busy = 0;

  always #5  fast_clk = ~fast_clk;
  always #50 slow_clk = ~slow_clk;

  dco_dither_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dco_dither_mod (
    .slow_clk(slow_clk), .slow_rst(slow_rst), .load_i(load),
    .int_code_i(int_code), .frac_code_i(frac_code),
    .fast_clk(fast_clk), .fast_rst(fast_rst), .dco_code_o(dco_code));

  dco_dither_mod #(.INT_W(INT_W), .FRAC_W(0)) u_dco_dither_mod_f0 (
    .slow_clk(slow_clk), .slow_rst(slow_rst), .load_i(load),
    .int_code_i(int_code), .frac_code_i(1'b0),
    .fast_clk(fast_clk), .fast_rst(fast_rst), .dco_code_o(dco_code_f0));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: load codes in the slow domain, let them cross, hand item to monitor.
  task automatic drive(input int ival, input int fval);
    @(negedge slow_clk);
    int_code  = INT_W'(ival);
    frac_code = FRAC_W'(fval);
    load      = 1;
    @(negedge slow_clk);
    load = 0;
    repeat (10) @(posedge fast_clk);
    sb_q.push_back('{ival, fval});
    mon_busy = 1;
    wait (!mon_busy);
  endtask

  // Monitor: sample a run of outputs and judge it against the popped item.
  initial begin
    forever begin
      item_t it;
      int s[NS];
      int err, worst, ones;
      bit sat;
      wait (sb_q.size() > 0);
      it  = sb_q.pop_front();
      sat = (it.ival == (1 << INT_W) - 1);
      for (int k = 0; k < NS; k++) begin
        @(negedge fast_clk);
        s[k] = int'(dco_code);
        if (k == 0) check(s[0] >= it.ival && s[0] <= it.ival + 1, "R5", s[0], it.ival);
        check(dco_code_f0 == INT_W'(it.ival), "R8", int'(dco_code_f0), it.ival);
      end
      if (sat) begin
        for (int k = 0; k < NS; k++) check(s[k] == it.ival, "R7", s[k], it.ival);
      end else begin
        for (int k = 0; k < NS; k++)
          check(s[k] == it.ival || s[k] == it.ival + 1, "R2", s[k], it.ival);
        for (int st = 0; st + PER <= NS; st++) begin
          ones = 0;
          for (int k = st; k < st + PER; k++) ones += (s[k] - it.ival);
          check(ones == it.fval, "R3", ones, it.fval);
        end
        err = 0; worst = 0;
        for (int k = 0; k < NS; k++) begin
          err += PER * (s[k] - it.ival) - it.fval;
          if (err > worst) worst = err;
          if (-err > worst) worst = -err;
        end
        check(worst < PER, "R4", worst, PER - 1);
      end
      mon_busy = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge fast_clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge slow_clk);
    @(negedge fast_clk);
    check(dco_code == '0, "R1", int'(dco_code), 0);
    @(negedge slow_clk);
    slow_rst = 0;
    @(negedge fast_clk);
    fast_rst = 0;
    @(negedge fast_clk);
    check(dco_code == '0, "R1", int'(dco_code), 0);

    drive(100, 32);    // alternating pattern
    drive(100, 1);     // sparse carries, residue kept from previous (R6)
    drive(257, 63);    // dense carries
    drive(5, 0);       // no carries
    drive(700, 21);    // residue left nonzero, then change (R6)
    drive(701, 43);
    drive(1023, 40);   // saturation R7
    drive(1022, 63);   // just below the top
    drive(0, 17);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule